// File: doc/BRIEF.md
# Daisy-Chain Command Frame Decoder

This block sits behind the UART receiver of one node in a serial chain of hashing chips. It watches the received byte stream for command frames, checks their length and check byte, and executes those aimed at this node: register writes and reads on a small word register file, setting the node's logical address, and switching off the relay of bytes to the next node in the chain. A register read produces a reply frame, which is handed byte by byte to a UART transmitter through a valid/ready pair.

The decoder state machine has eight states. ST_HUNT_A waits for 0x55 and moves to ST_HUNT_B. ST_HUNT_B moves to ST_HDR on 0xAA, stays on a repeated 0x55, and returns to ST_HUNT_A on anything else. ST_HDR checks the type and moves to ST_LEN. ST_LEN compares the length and moves to ST_ADDR. ST_ADDR moves to ST_REG. ST_REG moves to ST_DATA for long frames and to ST_CHK for short ones. ST_DATA moves to ST_CHK after four bytes. ST_CHK always returns to ST_HUNT_A and fires the command when the check byte matches. An idle gap abort leads from any state other than ST_HUNT_A back to ST_HUNT_A. The reply serializer has two states: TX_IDLE, which moves to TX_SEND when a read is executed, and TX_SEND, which returns to TX_IDLE after the last byte is accepted.

To number a chain, a controller broadcasts chain-inactive so that every node stops relaying. It then repeatedly sends set-address to address 0. Only the first node that is still unnumbered sees the command; it takes the address and opens its relay to the next node. Addresses may be any 8-bit value, so the controller can space them across the nonce range.

Top module: `chain_node_decoder`

## Requirements
- R1: After reset the node address is 0, relaying is on, the word at register byte 0x04 is 0x80000000, the word at 0x08 is 0xC0600161, the words at 0x0C and 0x10 are 0, and no reply byte or relay byte is valid.
- R2: A command frame is 0x55, 0xAA, a header byte (bit 7 = broadcast, bit 6 = write, bits 5:0 = type), a length byte, a target address byte, a register byte, four data bytes (most significant first) for long frames only, and a check byte equal to the XOR of all bytes from the header byte through the last byte before the check byte.
- R3: Type 1 (job) and type 2 with the write bit set are long frames with length 9. Type 2 read and type 3 (chain-inactive) are short frames with length 5. A frame with another type, a wrong length or a wrong check byte has no effect.
- R4: A byte that breaks the preamble returns the search to its start. A 0x55 where 0xAA is expected is taken as a fresh first preamble byte.
- R5: Once a frame has started, more than gap_limit consecutive clock cycles without a received byte discard the partial frame, and its remaining bytes have no effect.
- R6: A command is executed only if its broadcast bit is 1 or its target address equals the node address.
- R7: A register write to register byte 4*(k+1), k = 0..3, replaces that word. A read returns its current value. Writes to any other nonzero register byte have no effect, and reads of them return 0.
- R8: A register read produces the reply 0xAA, 0x55, 0x00, node address, register byte, four data bytes (most significant first), and a check byte equal to the XOR of the seven bytes after the preamble. tx_valid stays high and tx_byte is held while tx_ready is low.
- R9: While relaying is on, every received byte appears on relay_byte with relay_valid one cycle later, unchanged.
- R10: A targeted chain-inactive command turns relaying off after its own check byte has been relayed.
- R11: A write to register byte 0x00 sets the node address to data bits 7:0, but only while the node address is 0. It also turns relaying back on, and later writes to 0x00 have no effect. A read of 0x00 returns the address in bits 7:0.
- R12: A job frame changes no register, no address and no relay setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gap_limit | input | GAP_W | Idle cycles tolerated inside a frame |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| relay_valid | output | 1 | Byte strobe toward the downstream node |
| relay_byte | output | 8 | Byte toward the downstream node |
| tx_ready | input | 1 | Transmitter can accept a reply byte |
| tx_valid | output | 1 | Reply byte is valid |
| tx_byte | output | 8 | Reply byte |

## Verification
On every cycle, the assertions check that an accepted frame fires exactly one command pulse, that the gap counter never exceeds the limit inside a frame, that a nonzero address never changes, that relaying is only switched off by a chain-inactive command, and that a stalled reply byte is held and each reply opens with 0xAA. Only the bench scenarios can show the values themselves: the reset words, the write and read results over the whole register map, the rejection of bad lengths, bad check bytes, misaddressed and aborted frames, and the complete enumeration sequence with arbitrary address values.

// File: rtl/chain_cmd_pkg.sv
package chain_cmd_pkg;

    localparam logic [7:0] CMD_PRE_A = 8'h55;
    localparam logic [7:0] CMD_PRE_B = 8'hAA;
    localparam logic [7:0] RSP_PRE_A = 8'hAA;
    localparam logic [7:0] RSP_PRE_B = 8'h55;
    localparam logic [7:0] RSP_TYPE_READ = 8'h00;
    localparam logic [7:0] LEN_SHORT = 8'd5;
    localparam logic [7:0] LEN_LONG  = 8'd9;
    localparam logic [7:0] REG_NODE_ADDR = 8'h00;

    typedef enum logic [2:0] {
        TY_NONE  = 3'd0,
        TY_JOB   = 3'd1,
        TY_REG   = 3'd2,
        TY_INACT = 3'd3
    } cmd_type_e;

    typedef struct packed {
        logic       all;
        logic       wr;
        cmd_type_e  typ;
        logic [7:0] addr;
        logic [7:0] reg_id;
        logic [31:0] data;
    } cmd_t;

endpackage

// File: rtl/chain_frame_rx.sv
module chain_frame_rx
    import chain_cmd_pkg::*;
#(
    parameter int GAP_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [GAP_W-1:0] gap_limit,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    output logic             cmd_fire,
    output cmd_t             cmd
);

    typedef enum logic [2:0] {
        ST_HUNT_A, ST_HUNT_B, ST_HDR, ST_LEN,
        ST_ADDR, ST_REG, ST_DATA, ST_CHK
    } rx_state_e;

    rx_state_e        st_q, st_d;
    logic [GAP_W-1:0] gap_q;
    logic             all_q, wr_q, fire_q;
    cmd_type_e        typ_q;
    logic [7:0]       addr_q, reg_q, chk_q;
    logic [31:0]      data_q;
    logic [1:0]       dcnt_q;
    logic             gap_hit, hdr_ok, long_frm;
    logic [7:0]       want_len;

    assign gap_hit  = (st_q != ST_HUNT_A) && !rx_valid && (gap_q >= gap_limit);
    assign hdr_ok   = (rx_byte[5:0] == 6'd1) || (rx_byte[5:0] == 6'd2) ||
                      (rx_byte[5:0] == 6'd3);
    assign long_frm = (typ_q == TY_JOB) || ((typ_q == TY_REG) && wr_q);
    assign want_len = long_frm ? LEN_LONG : LEN_SHORT;

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (gap_hit) begin
            st_d = ST_HUNT_A;
        end else if (rx_valid) begin
            unique case (st_q)
                ST_HUNT_A: st_d = (rx_byte == CMD_PRE_A) ? ST_HUNT_B : ST_HUNT_A;
                ST_HUNT_B: begin
                    if (rx_byte == CMD_PRE_B)      st_d = ST_HDR;
                    else if (rx_byte == CMD_PRE_A) st_d = ST_HUNT_B;
                    else                           st_d = ST_HUNT_A;
                end
                ST_HDR:  st_d = hdr_ok ? ST_LEN : ST_HUNT_A;
                ST_LEN:  st_d = (rx_byte == want_len) ? ST_ADDR : ST_HUNT_A;
                ST_ADDR: st_d = ST_REG;
                ST_REG:  st_d = long_frm ? ST_DATA : ST_CHK;
                ST_DATA: st_d = (dcnt_q == 2'd3) ? ST_CHK : ST_DATA;
                ST_CHK:  st_d = ST_HUNT_A;
                default: st_d = ST_HUNT_A;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_HUNT_A;
        else     st_q <= st_d;
    end

    // field capture and command pulse
    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            all_q  <= 1'b0;
            wr_q   <= 1'b0;
            typ_q  <= TY_NONE;
            addr_q <= '0;
            reg_q  <= '0;
            chk_q  <= '0;
            data_q <= '0;
            dcnt_q <= '0;
            fire_q <= 1'b0;
        end else begin
            fire_q <= 1'b0;
            if (rx_valid || (st_q == ST_HUNT_A)) gap_q <= '0;
            else if (gap_q != '1)                gap_q <= gap_q + 1'b1;
            if (rx_valid) begin
                unique case (st_q)
                    ST_HDR: begin
                        all_q  <= rx_byte[7];
                        wr_q   <= rx_byte[6];
                        typ_q  <= cmd_type_e'(rx_byte[2:0]);
                        chk_q  <= rx_byte;
                        data_q <= '0;
                        dcnt_q <= '0;
                    end
                    ST_LEN: chk_q <= chk_q ^ rx_byte;
                    ST_ADDR: begin
                        addr_q <= rx_byte;
                        chk_q  <= chk_q ^ rx_byte;
                    end
                    ST_REG: begin
                        reg_q <= rx_byte;
                        chk_q <= chk_q ^ rx_byte;
                    end
                    ST_DATA: begin
                        data_q <= {data_q[23:0], rx_byte};
                        dcnt_q <= dcnt_q + 2'd1;
                        chk_q  <= chk_q ^ rx_byte;
                    end
                    ST_CHK:  fire_q <= (rx_byte == chk_q);
                    default: ;
                endcase
            end
        end
    end

    assign cmd_fire   = fire_q;
    assign cmd.all    = all_q;
    assign cmd.wr     = wr_q;
    assign cmd.typ    = typ_q;
    assign cmd.addr   = addr_q;
    assign cmd.reg_id = reg_q;
    assign cmd.data   = data_q;

    // R3: an accepted frame yields a single-cycle command pulse
    p_fire_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_fire |=> !cmd_fire);

    // R5: inside a frame the idle counter never passes the limit
    p_gap_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_HUNT_A) |-> (gap_q <= gap_limit));

endmodule

// File: rtl/chain_node_state.sv
module chain_node_state
    import chain_cmd_pkg::*;
#(
    parameter int NWORDS = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_fire,
    input  cmd_t        cmd,
    output logic [7:0]  node_addr,
    output logic        fwd_en,
    output logic [31:0] rd_data,
    output logic        rd_go
);

    function automatic logic [31:0] word_init(input int k);
        case (k)
            0:       return 32'h8000_0000;
            1:       return 32'hC060_0161;
            default: return 32'h0000_0000;
        endcase
    endfunction

    logic [NWORDS-1:0]       hit;
    logic [NWORDS-1:0][31:0] word_q;
    logic targeted, addr_sel, do_wr, set_ok, go_quiet;

    for (genvar k = 0; k < NWORDS; k++) begin : g_dec
        localparam logic [7:0] OFS = 8'((k + 1) * 4);
        assign hit[k] = (cmd.reg_id == OFS);
    end

    assign targeted = cmd.all || (cmd.addr == node_addr);
    assign addr_sel = (cmd.reg_id == REG_NODE_ADDR);
    assign do_wr    = cmd_fire && targeted && (cmd.typ == TY_REG) && cmd.wr;
    assign rd_go    = cmd_fire && targeted && (cmd.typ == TY_REG) && !cmd.wr;
    assign set_ok   = do_wr && addr_sel && (node_addr == 8'h00);
    assign go_quiet = cmd_fire && targeted && (cmd.typ == TY_INACT);

    always_ff @(posedge clk) begin
        if (rst) begin
            node_addr <= 8'h00;
            fwd_en    <= 1'b1;
            for (int k = 0; k < NWORDS; k++) word_q[k] <= word_init(k);
        end else begin
            if (set_ok) begin
                node_addr <= cmd.data[7:0];
                fwd_en    <= 1'b1;
            end else if (go_quiet) begin
                fwd_en <= 1'b0;
            end
            for (int k = 0; k < NWORDS; k++) begin
                if (do_wr && hit[k]) word_q[k] <= cmd.data;
            end
        end
    end

    always_comb begin
        rd_data = addr_sel ? {24'h0, node_addr} : 32'h0;
        for (int k = 0; k < NWORDS; k++) begin
            if (hit[k]) rd_data = rd_data | word_q[k];
        end
    end

    // R11: once numbered, the address stays fixed
    p_addr_lock_r11: assert property (@(posedge clk) disable iff (rst)
        (node_addr != 8'h00) |=> (node_addr == $past(node_addr)));

    // R10: relaying is switched off only by a chain-inactive command
    p_quiet_cause_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(fwd_en) |-> $past(cmd_fire && (cmd.typ == TY_INACT)));

endmodule

// File: rtl/chain_resp_tx.sv
module chain_resp_tx
    import chain_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        go,
    input  logic [7:0]  node_addr,
    input  logic [7:0]  reg_id,
    input  logic [31:0] rd_data,
    input  logic        tx_ready,
    output logic        tx_valid,
    output logic [7:0]  tx_byte
);

    localparam int FRM_LEN = 10;
    localparam int IDX_W   = $clog2(FRM_LEN);

    typedef enum logic {TX_IDLE, TX_SEND} tx_state_e;

    tx_state_e                st_q, st_d;
    logic [FRM_LEN-1:0][7:0]  frm_d, frm_q;
    logic [IDX_W-1:0]         idx_q;
    logic                     last;

    assign last = (idx_q == IDX_W'(FRM_LEN - 1));

    always_comb begin
        frm_d[0] = RSP_PRE_A;
        frm_d[1] = RSP_PRE_B;
        frm_d[2] = RSP_TYPE_READ;
        frm_d[3] = node_addr;
        frm_d[4] = reg_id;
        frm_d[5] = rd_data[31:24];
        frm_d[6] = rd_data[23:16];
        frm_d[7] = rd_data[15:8];
        frm_d[8] = rd_data[7:0];
        frm_d[9] = RSP_TYPE_READ ^ node_addr ^ reg_id ^ rd_data[31:24] ^
                   rd_data[23:16] ^ rd_data[15:8] ^ rd_data[7:0];
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TX_IDLE: if (go) st_d = TX_SEND;
            TX_SEND: if (tx_ready && last) st_d = TX_IDLE;
            default: st_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= TX_IDLE;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frm_q <= '0;
            idx_q <= '0;
        end else if (st_q == TX_IDLE) begin
            if (go) begin
                frm_q <= frm_d;
                idx_q <= '0;
            end
        end else if (tx_ready && !last) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign tx_valid = (st_q == TX_SEND);
    assign tx_byte  = frm_q[idx_q];

    // R8: a stalled reply byte is held
    p_tx_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

    // R8: every reply opens with the first response preamble byte
    p_tx_start_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> (tx_byte == RSP_PRE_A));

endmodule

// File: rtl/chain_node_decoder.sv
module chain_node_decoder
    import chain_cmd_pkg::*;
#(
    parameter int GAP_W  = 16,
    parameter int NWORDS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [GAP_W-1:0] gap_limit,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    output logic             relay_valid,
    output logic [7:0]       relay_byte,
    input  logic             tx_ready,
    output logic             tx_valid,
    output logic [7:0]       tx_byte
);

    logic        cmd_fire, fwd_en, rd_go;
    cmd_t        cmd;
    logic [7:0]  node_addr;
    logic [31:0] rd_data;

    chain_frame_rx #(.GAP_W(GAP_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .gap_limit(gap_limit),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .cmd_fire (cmd_fire),
        .cmd      (cmd)
    );

    chain_node_state #(.NWORDS(NWORDS)) u_state (
        .clk      (clk),
        .rst      (rst),
        .cmd_fire (cmd_fire),
        .cmd      (cmd),
        .node_addr(node_addr),
        .fwd_en   (fwd_en),
        .rd_data  (rd_data),
        .rd_go    (rd_go)
    );

    chain_resp_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .go       (rd_go),
        .node_addr(node_addr),
        .reg_id   (cmd.reg_id),
        .rd_data  (rd_data),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_byte  (tx_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            relay_valid <= 1'b0;
            relay_byte  <= 8'h00;
        end else begin
            relay_valid <= rx_valid && fwd_en;
            relay_byte  <= rx_byte;
        end
    end

endmodule

// File: tb/chain_node_decoder_bench.sv
module chain_node_decoder_bench;

    localparam int CLK_PERIOD = 10;
    localparam int GAP_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [GAP_W-1:0] gap_limit = 16'd20;
    logic             rx_valid = 1'b0;
    logic [7:0]       rx_byte = 8'h00;
    logic             relay_valid;
    logic [7:0]       relay_byte;
    logic             tx_ready = 1'b1;
    logic             tx_valid;
    logic [7:0]       tx_byte;

    int checks = 0;
    int errors = 0;

    logic [7:0]  txq[$];
    logic [7:0]  rlq[$];
    logic [7:0]  sentq[$];
    logic [7:0]  m_addr;
    logic [31:0] m_w[4];

    always #(CLK_PERIOD / 2) clk = ~clk;

    chain_node_decoder u_chain_node_decoder (
        .clk(clk), .rst(rst), .gap_limit(gap_limit),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .relay_valid(relay_valid), .relay_byte(relay_byte),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte)
    );

    always @(negedge clk) begin
        if (!rst && tx_valid && tx_ready) txq.push_back(tx_byte);
        if (!rst && relay_valid) rlq.push_back(relay_byte);
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [7:0] rg);
        case (rg)
            8'h00:   return {24'h0, m_addr};
            8'h04:   return m_w[0];
            8'h08:   return m_w[1];
            8'h0C:   return m_w[2];
            8'h10:   return m_w[3];
            default: return 32'h0;
        endcase
    endfunction

    task automatic put(input logic [7:0] b);
        @(posedge clk); #1;
        rx_valid = 1'b1; rx_byte = b; sentq.push_back(b);
        @(posedge clk); #1;
        rx_valid = 1'b0;
        @(posedge clk);
    endtask

    task automatic frame(input bit all, input bit wr, input logic [5:0] ty,
                         input logic [7:0] ad, input logic [7:0] rg,
                         input logic [31:0] d, input logic [7:0] len_adj,
                         input logic [7:0] chk_flip);
        logic [7:0] h, ln, c;
        bit lng;
        h   = {all, wr, ty};
        lng = (ty == 6'd1) || ((ty == 6'd2) && wr);
        ln  = (lng ? 8'd9 : 8'd5) + len_adj;
        c   = h ^ ln ^ ad ^ rg;
        if (lng) c = c ^ d[31:24] ^ d[23:16] ^ d[15:8] ^ d[7:0];
        put(8'h55); put(8'hAA); put(h); put(ln); put(ad); put(rg);
        if (lng) begin
            put(d[31:24]); put(d[23:16]); put(d[15:8]); put(d[7:0]);
        end
        put(c ^ chk_flip);
        repeat (4) @(posedge clk);
    endtask

    task automatic wr_reg(input bit all, input logic [7:0] ad, input logic [7:0] rg,
                          input logic [31:0] d);
        frame(all, 1'b1, 6'd2, ad, rg, d, 8'd0, 8'd0);
    endtask

    task automatic check_reply(input string req, input logic [7:0] rg);
        logic [7:0] e[10];
        logic [31:0] d;
        bit ok;
        logic [63:0] act, exp;
        d = exp_read(rg);
        e[0] = 8'hAA; e[1] = 8'h55; e[2] = 8'h00; e[3] = m_addr; e[4] = rg;
        e[5] = d[31:24]; e[6] = d[23:16]; e[7] = d[15:8]; e[8] = d[7:0];
        e[9] = 8'h00 ^ m_addr ^ rg ^ d[31:24] ^ d[23:16] ^ d[15:8] ^ d[7:0];
        ok = (txq.size() == 10);
        act = 64'(txq.size()); exp = 64'd10;
        if (ok) begin
            for (int i = 0; i < 10; i++) begin
                if (ok && txq[i] != e[i]) begin
                    ok = 1'b0; act = 64'(txq[i]); exp = 64'(e[i]);
                end
            end
        end
        check(ok, req, act, exp);
        txq.delete();
    endtask

    task automatic rd_check(input string req, input bit all, input logic [7:0] ad,
                            input logic [7:0] rg);
        txq.delete();
        frame(all, 1'b0, 6'd2, ad, rg, 32'h0, 8'd0, 8'd0);
        repeat (20) @(posedge clk);
        check_reply(req, rg);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1; rx_valid = 1'b0; tx_ready = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        m_addr = 8'h00;
        m_w[0] = 32'h8000_0000; m_w[1] = 32'hC060_0161;
        m_w[2] = 32'h0; m_w[3] = 32'h0;
        txq.delete(); rlq.delete(); sentq.delete();
        @(posedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(1'b0, "watchdog", 64'd0, 64'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0] a;
        do_reset();

        // R1: reset state at the ports
        @(negedge clk);
        check(!tx_valid && !relay_valid, "R1 idle outputs",
              {tx_valid, relay_valid}, 64'd0);
        rd_check("R1 word 0x04", 1'b0, 8'h00, 8'h04);
        rd_check("R1 word 0x08", 1'b0, 8'h00, 8'h08);
        rd_check("R1 word 0x0C", 1'b0, 8'h00, 8'h0C);
        rd_check("R1 address", 1'b0, 8'h00, 8'h00);

        // R9: a read frame is relayed byte for byte
        sentq.delete(); rlq.delete();
        rd_check("R9 read during relay", 1'b0, 8'h00, 8'h10);
        check(rlq == sentq, "R9 relay copy", 64'(rlq.size()), 64'(sentq.size()));

        // R2 R7: write every word then read them all back
        for (int k = 0; k < 4; k++) begin
            v = (32'h9E37_79B9 * 32'(k + 1)) ^ (32'(k) << 28);
            wr_reg(1'b0, 8'h00, 8'(4 * (k + 1)), v);
            m_w[k] = v;
        end
        for (int k = 0; k < 4; k++) rd_check("R2 R7 word readback", 1'b0, 8'h00, 8'(4 * (k + 1)));

        // R7: unmapped register bytes
        wr_reg(1'b0, 8'h00, 8'h05, 32'h1111_2222);
        wr_reg(1'b0, 8'h00, 8'h14, 32'h3333_4444);
        rd_check("R7 unmapped 0x05", 1'b0, 8'h00, 8'h05);
        rd_check("R7 unmapped 0x14", 1'b0, 8'h00, 8'h14);
        rd_check("R7 neighbour 0x10 intact", 1'b0, 8'h00, 8'h10);

        // R3: bad check byte and bad length
        frame(1'b0, 1'b1, 6'd2, 8'h00, 8'h0C, 32'h0102_0304, 8'd0, 8'hFF);
        rd_check("R3 bad check ignored", 1'b0, 8'h00, 8'h0C);
        frame(1'b0, 1'b1, 6'd2, 8'h00, 8'h0C, 32'h0102_0304, 8'd1, 8'h00);
        rd_check("R3 bad length ignored", 1'b0, 8'h00, 8'h0C);
        frame(1'b0, 1'b0, 6'd2, 8'h00, 8'h08, 32'h0, 8'd0, 8'h01);
        repeat (20) @(posedge clk);
        check(txq.size() == 0, "R3 corrupt read no reply", 64'(txq.size()), 64'd0);
        frame(1'b0, 1'b1, 6'd6, 8'h00, 8'h0C, 32'h0102_0304, 8'd0, 8'h00);
        rd_check("R3 unknown type ignored", 1'b0, 8'h00, 8'h0C);

        // R4: noise before and a doubled first preamble byte
        put(8'h12); put(8'h55); put(8'h13); put(8'h55);
        wr_reg(1'b0, 8'h00, 8'h0C, 32'h0BAD_F00D);
        m_w[2] = 32'h0BAD_F00D;
        rd_check("R4 resync after noise", 1'b0, 8'h00, 8'h0C);

        // R5: idle gap inside a frame aborts it
        put(8'h55); put(8'hAA); put(8'h42); put(8'h09); put(8'h00); put(8'h0C);
        repeat (40) @(posedge clk);
        put(8'h01); put(8'h02); put(8'h03); put(8'h04); put(8'h43);
        repeat (4) @(posedge clk);
        rd_check("R5 aborted frame ignored", 1'b0, 8'h00, 8'h0C);

        // R6: targeting
        wr_reg(1'b0, 8'h07, 8'h04, 32'h7777_0000);
        rd_check("R6 mismatched address ignored", 1'b0, 8'h00, 8'h04);
        wr_reg(1'b1, 8'h07, 8'h04, 32'h7777_0001);
        m_w[0] = 32'h7777_0001;
        rd_check("R6 broadcast applied", 1'b0, 8'h00, 8'h04);
        txq.delete();
        frame(1'b0, 1'b0, 6'd2, 8'h07, 8'h04, 32'h0, 8'd0, 8'd0);
        repeat (20) @(posedge clk);
        check(txq.size() == 0, "R6 read other node no reply", 64'(txq.size()), 64'd0);

        // R12: job frame changes nothing
        frame(1'b1, 1'b0, 6'd1, 8'h00, 8'h04, 32'hDEAD_BEEF, 8'd0, 8'd0);
        frame(1'b1, 1'b1, 6'd1, 8'h00, 8'h08, 32'hFEED_0001, 8'd0, 8'd0);
        rd_check("R12 job leaves 0x04", 1'b0, 8'h00, 8'h04);
        rd_check("R12 job leaves 0x08", 1'b0, 8'h00, 8'h08);

        // R8: stalled transmitter
        #1 tx_ready = 1'b0;
        txq.delete();
        frame(1'b0, 1'b0, 6'd2, 8'h00, 8'h08, 32'h0, 8'd0, 8'd0);
        repeat (20) @(posedge clk);
        @(negedge clk);
        check(tx_valid && tx_byte == 8'hAA && txq.size() == 0, "R8 stall holds first byte",
              {tx_valid, tx_byte}, {1'b1, 8'hAA});
        @(posedge clk); #1 tx_ready = 1'b1;
        repeat (20) @(posedge clk);
        check_reply("R8 reply after stall", 8'h08);

        // R10: chain-inactive stops relaying after itself
        sentq.delete(); rlq.delete();
        frame(1'b1, 1'b0, 6'd3, 8'h00, 8'h00, 32'h0, 8'd0, 8'd0);
        check(rlq == sentq, "R10 inactive frame relayed", 64'(rlq.size()), 64'(sentq.size()));
        sentq.delete(); rlq.delete();
        rd_check("R10 node still answers", 1'b0, 8'h00, 8'h04);
        check(rlq.size() == 0, "R10 relay quiet", 64'(rlq.size()), 64'd0);

        // R11: set-address, relay reopens, later writes ignored
        sentq.delete(); rlq.delete();
        wr_reg(1'b0, 8'h00, 8'h00, 32'h0000_005C);
        m_addr = 8'h5C;
        check(rlq.size() == 0, "R11 set frame not relayed", 64'(rlq.size()), 64'd0);
        sentq.delete(); rlq.delete();
        rd_check("R11 new address", 1'b0, 8'h5C, 8'h00);
        check(rlq == sentq, "R11 relay reopened", 64'(rlq.size()), 64'(sentq.size()));
        wr_reg(1'b1, 8'h00, 8'h00, 32'h0000_0033);
        rd_check("R11 second set ignored", 1'b0, 8'h5C, 8'h00);
        txq.delete();
        frame(1'b0, 1'b0, 6'd2, 8'h00, 8'h04, 32'h0, 8'd0, 8'd0);
        repeat (20) @(posedge clk);
        check(txq.size() == 0, "R6 R11 old address silent", 64'(txq.size()), 64'd0);

        // R11: arbitrary, non-consecutive addresses
        for (int i = 0; i < 6; i++) begin
            a = 8'(i * 53 + 7);
            do_reset();
            wr_reg(1'b0, 8'h00, 8'h00, {24'hABCDEF, a});
            m_addr = a;
            rd_check("R11 address sweep", 1'b0, a, 8'h00);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule